// File: doc/BRIEF.md
# Configurable Address Space Decoder

This block turns a 32-bit processor address into exactly one chip select. Every address falls into one of two halves. The lower half is RAM. The upper half holds the screen buffer, a ROM window and a megabyte of I/O, split into 64 KB device windows. How many of the upper address bits count depends on two things: a 5-bit map register and the privilege bit. The decode space can therefore be 16 MB, 32 MB, 512 MB or 4 GB. Any bit that does not take part in decoding is ignored, so software may keep tags in the top byte of a pointer in the 16 MB configuration.

The map register is written through a one-cycle write strobe. Two of its bits let the 1 MB RAM region at offset zero, and the one at offset 0x400000, answer as ROM instead of RAM. This lets reset vectors come from ROM. An address that lands in a hole or a reserved area drives no chip select and raises a decode-error output instead.

Top module: `addrmap_decoder`

## Requirements
- R1: Reset (synchronous, active high) loads the map register with 5'b00101. This is the 16 MB configuration with the zero-region ROM overlay on, so address 0 selects ROM once reset is released.
- R2: A write (map_wr_en high) updates the map register at the next rising clock edge. The outputs are combinational from the registered map, addr and supervisor.
- R3: When supervisor is 1, the space is 16 MB whatever the map bits hold. If addr[23] is 0 the access goes to the RAM half; if it is 1 it goes to the upper half.
- R4: In user state (supervisor 0), map bits [4:2] pick the space by priority. map[2]=1 selects 16 MB; otherwise map[3]=1 selects 32 MB; otherwise map[4]=1 selects 512 MB; otherwise the space is 4 GB. The bit that splits the halves is addr[23], addr[24], addr[28] or addr[31] respectively.
- R5: An access in the upper half is valid only if all of its select bits are 1. These are addr[23] for 16 MB; addr[24] and addr[23] for 32 MB; addr[28], addr[24] and addr[23] for 512 MB; and addr[31], addr[28], addr[24] and addr[23] for 4 GB. If the split bit is set but any other select bit is clear, decode_err is raised.
- R6: Address bits that are neither select bits nor below the split bit have no effect on the outputs. In particular, addr[31:24] is ignored in the 16 MB configuration.
- R7: When the split bit is 0, cs_ram is asserted unless an overlay applies (R8).
- R8: Within the RAM half, with offset = addr masked below the split bit: if map[0]=1 and offset[31:20]=0, cs_rom is asserted instead of cs_ram. If map[1]=1 and offset[31:20]=12'h004, cs_rom is also asserted instead of cs_ram.
- R9: In the upper half, the megabyte index addr[22:20] picks the target. Index 3'b001 is the screen, 3'b100 is the fixed ROM window, 3'b111 is I/O, and every other index raises decode_err.
- R10: In the I/O megabyte, cs_io[addr[19:16]] is the only I/O select asserted. The fixed device windows are: 9 disk interface, 10 and 11 serial channels, 12 floppy, 13 shared timing/sound/clock/input window, 14 DMA, 15 system register. Windows 0–8 are slot space.
- R11: At all times, exactly one of cs_ram, cs_screen, cs_rom, the 16 bits of cs_io, and decode_err is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_data | input | 5 | New map register value |
| addr | input | 32 | Processor address |
| supervisor | input | 1 | Privilege bit, 1 = supervisor |
| cs_ram | output | 1 | RAM select |
| cs_screen | output | 1 | Screen buffer select |
| cs_rom | output | 1 | ROM select (overlay or fixed window) |
| cs_io | output | 16 | One select per 64 KB I/O window |
| decode_err | output | 1 | Address maps to nothing |

## Verification
The assertions assume addr, supervisor and the write port are known, not X, outside reset. They also assume the write strobe is sampled only at clock edges. The stimulus changes every input on the falling edge only and never leaves any of them undriven. The supervisor-state properties depend on the map register holding a value written through the port. The bench writes only through map_wr_en, and both random and directed writes stay inside the 5-bit field.

// File: rtl/addrdec_pkg.sv
package addrdec_pkg;

    localparam int ADDR_W    = 32;
    localparam int MAP_W     = 5;
    localparam int IO_SEL_W  = 4;
    localparam int IO_WIN    = 1 << IO_SEL_W;
    localparam int MB_LSB    = 20;
    localparam int WIN_LSB   = MB_LSB - IO_SEL_W;
    localparam int IDX_W     = 3;

    localparam logic [MAP_W-1:0] RESET_MAP = 5'b00101;

    localparam logic [IDX_W-1:0] IDX_SCREEN = 3'b001;
    localparam logic [IDX_W-1:0] IDX_ROM_HI = 3'b100;
    localparam logic [IDX_W-1:0] IDX_IO     = 3'b111;

    localparam logic [ADDR_W-MB_LSB-1:0] MB_ZERO = '0;
    localparam logic [ADDR_W-MB_LSB-1:0] MB_LOW  = 12'h004;

    typedef enum logic [1:0] {
        SPAN_16M  = 2'd0,
        SPAN_32M  = 2'd1,
        SPAN_512M = 2'd2,
        SPAN_4G   = 2'd3
    } span_e;

    typedef struct packed {
        span_e span;
        logic  ovl_zero;
        logic  ovl_low;
    } map_cfg_t;

    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_HIGH = 2'd1,
        REG_HOLE = 2'd2
    } region_e;

    function automatic logic [4:0] split_bit(span_e s);
        case (s)
            SPAN_16M:  return 5'd23;
            SPAN_32M:  return 5'd24;
            SPAN_512M: return 5'd28;
            default:   return 5'd31;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] select_mask(span_e s);
        case (s)
            SPAN_16M:  return 32'h0080_0000;
            SPAN_32M:  return 32'h0180_0000;
            SPAN_512M: return 32'h1180_0000;
            default:   return 32'h9180_0000;
        endcase
    endfunction

    function automatic span_e span_of(logic [MAP_W-1:0] m, logic sup);
        if (sup || m[2]) return SPAN_16M;
        else if (m[3])   return SPAN_32M;
        else if (m[4])   return SPAN_512M;
        else             return SPAN_4G;
    endfunction

endpackage

// File: rtl/addrdec_map_reg.sv
module addrdec_map_reg
    import addrdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [MAP_W-1:0] wr_data,
    input  logic             supervisor,
    output logic [MAP_W-1:0] map_q,
    output map_cfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= RESET_MAP;
        end else if (wr_en) begin
            map_q <= wr_data;
        end
    end

    always_comb begin
        cfg.span     = span_of(map_q, supervisor);
        cfg.ovl_zero = map_q[0];
        cfg.ovl_low  = map_q[1];
    end

endmodule

// File: rtl/addrdec_span_sel.sv
module addrdec_span_sel
    import addrdec_pkg::*;
(
    input  map_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              overlay_hit
);

    logic [4:0]              sb;
    logic [ADDR_W-1:0]       sel_mask;
    logic [ADDR_W-1:0]       below_mask;
    logic [ADDR_W-1:0]       offset;
    logic [ADDR_W-MB_LSB-1:0] mb;
    logic                    split;
    logic                    all_sel;

    always_comb begin
        sb         = split_bit(cfg.span);
        sel_mask   = select_mask(cfg.span);
        below_mask = (32'h1 << sb) - 32'h1;
        offset     = addr & below_mask;
        mb         = offset[ADDR_W-1:MB_LSB];
        split      = addr[sb];
        all_sel    = ((addr & sel_mask) == sel_mask);

        if (!split) begin
            region = REG_RAM;
        end else if (all_sel) begin
            region = REG_HIGH;
        end else begin
            region = REG_HOLE;
        end

        overlay_hit = (cfg.ovl_zero && (mb == MB_ZERO)) ||
                      (cfg.ovl_low  && (mb == MB_LOW));
    end

endmodule

// File: rtl/addrdec_high_dec.sv
module addrdec_high_dec
    import addrdec_pkg::*;
(
    input  logic [IDX_W-1:0]    mb_idx,
    input  logic [IO_SEL_W-1:0] win,
    output logic                sel_screen,
    output logic                sel_rom,
    output logic [IO_WIN-1:0]   sel_io,
    output logic                sel_err
);

    logic io_mb;

    always_comb begin
        sel_screen = (mb_idx == IDX_SCREEN);
        sel_rom    = (mb_idx == IDX_ROM_HI);
        io_mb      = (mb_idx == IDX_IO);
        sel_err    = !(sel_screen || sel_rom || io_mb);
    end

    for (genvar i = 0; i < IO_WIN; i++) begin : g_win
        assign sel_io[i] = io_mb && (win == IO_SEL_W'(i));
    end

endmodule

// File: rtl/addrmap_decoder.sv
module addrmap_decoder
    import addrdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              map_wr_en,
    input  logic [MAP_W-1:0]  map_wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              supervisor,
    output logic              cs_ram,
    output logic              cs_screen,
    output logic              cs_rom,
    output logic [IO_WIN-1:0] cs_io,
    output logic              decode_err
);

    logic [MAP_W-1:0]  map_q;
    map_cfg_t          cfg;
    region_e           region;
    logic              overlay_hit;
    logic              h_screen;
    logic              h_rom;
    logic [IO_WIN-1:0] h_io;
    logic              h_err;

    addrdec_map_reg u_map (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (map_wr_en),
        .wr_data    (map_wr_data),
        .supervisor (supervisor),
        .map_q      (map_q),
        .cfg        (cfg)
    );

    addrdec_span_sel u_span (
        .cfg         (cfg),
        .addr        (addr),
        .region      (region),
        .overlay_hit (overlay_hit)
    );

    addrdec_high_dec u_high (
        .mb_idx     (addr[MB_LSB+IDX_W-1:MB_LSB]),
        .win        (addr[MB_LSB-1:WIN_LSB]),
        .sel_screen (h_screen),
        .sel_rom    (h_rom),
        .sel_io     (h_io),
        .sel_err    (h_err)
    );

    always_comb begin
        cs_ram     = 1'b0;
        cs_screen  = 1'b0;
        cs_rom     = 1'b0;
        cs_io      = '0;
        decode_err = 1'b0;
        case (region)
            REG_RAM: begin
                cs_ram = !overlay_hit;
                cs_rom = overlay_hit;
            end
            REG_HIGH: begin
                cs_screen  = h_screen;
                cs_rom     = h_rom;
                cs_io      = h_io;
                decode_err = h_err;
            end
            default: begin
                decode_err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/addrdec_checker.sv
module addrdec_checker
    import addrdec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              map_wr_en,
    input logic [MAP_W-1:0]  map_wr_data,
    input logic [ADDR_W-1:0] addr,
    input logic              supervisor,
    input logic [MAP_W-1:0]  map_q,
    input logic              cs_ram,
    input logic              cs_screen,
    input logic              cs_rom,
    input logic [IO_WIN-1:0] cs_io,
    input logic              decode_err
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: one edge after reset, the map holds the reset value
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            p_reset_map_r1: assert (map_q == RESET_MAP)
                else $error("p_reset_map_r1");
        end
    end

    p_one_sel_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({cs_ram, cs_screen, cs_rom, cs_io, decode_err}) == 1);

    p_wr_next_r2: assert property (@(posedge clk) disable iff (rst)
        map_wr_en |=> (map_q == $past(map_wr_data)));

    p_super_low_r3: assert property (@(posedge clk) disable iff (rst)
        (supervisor && !addr[23]) |-> (cs_ram || cs_rom));

    p_overlay_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (supervisor && addr[23:20] == 4'h0 && map_q[0]) |-> cs_rom);

    p_tag_free_r6: assert property (@(posedge clk) disable iff (rst)
        (supervisor && addr[23:16] == 8'hF9) |-> cs_io[9]);

endmodule

bind addrmap_decoder addrdec_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .map_wr_en   (map_wr_en),
    .map_wr_data (map_wr_data),
    .addr        (addr),
    .supervisor  (supervisor),
    .map_q       (map_q),
    .cs_ram      (cs_ram),
    .cs_screen   (cs_screen),
    .cs_rom      (cs_rom),
    .cs_io       (cs_io),
    .decode_err  (decode_err)
);

// File: tb/addrmap_decoder_bench.sv
module addrmap_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_wr_en = 1'b0;
    logic [4:0]  map_wr_data = 5'd0;
    logic [31:0] addr = 32'd0;
    logic        supervisor = 1'b1;
    logic        cs_ram, cs_screen, cs_rom, decode_err;
    logic [15:0] cs_io;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [4:0] model_map = 5'b00101;

    always #4 clk = ~clk;

    addrmap_decoder u_addrmap_decoder (
        .clk(clk), .rst(rst), .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
        .addr(addr), .supervisor(supervisor), .cs_ram(cs_ram),
        .cs_screen(cs_screen), .cs_rom(cs_rom), .cs_io(cs_io),
        .decode_err(decode_err)
    );

    always @(posedge clk) begin
        if (rst) model_map <= 5'b00101;          // R1
        else if (map_wr_en) model_map <= map_wr_data; // R2
    end

    // Expected vector {ram, screen, rom, io[15:0], err}
    function automatic logic [19:0] expect_of(input logic [31:0] a, input logic sup,
                                              input logic [4:0] m, output string tag);
        int hb;
        longint unsigned off;
        longint unsigned mbi;
        bit ok;
        logic [19:0] e;
        e = '0;
        if (sup) hb = 23;                        // R3
        else if (m[2]) hb = 23;                  // R4
        else if (m[3]) hb = 24;
        else if (m[4]) hb = 28;
        else hb = 31;
        if (!a[hb]) begin
            off = longint'(a) & ((64'd1 << hb) - 1);
            mbi = off >> 20;
            if ((mbi == 0 && m[0]) || (mbi == 4 && m[1])) begin
                e[17] = 1'b1; tag = "R8";
            end else begin
                e[19] = 1'b1; tag = "R7";
            end
        end else begin
            ok = a[23];
            if (hb >= 24) ok = ok && a[24];
            if (hb >= 28) ok = ok && a[28];
            if (hb >= 31) ok = ok && a[31];
            if (!ok) begin
                e[0] = 1'b1; tag = "R5";
            end else begin
                tag = "R9";
                case (a[22:20])
                    3'd1: e[18] = 1'b1;
                    3'd4: e[17] = 1'b1;
                    3'd7: begin e[1 + a[19:16]] = 1'b1; tag = "R10"; end
                    default: e[0] = 1'b1;
                endcase
            end
        end
        return e;
    endfunction

    task automatic compare(input string note);
        logic [19:0] exp_v, act;
        string tag;
        exp_v = expect_of(addr, supervisor, model_map, tag);
        act = {cs_ram, cs_screen, cs_rom, cs_io, decode_err};
        compared++;
        if (act !== exp_v) begin
            mismatched++;
            $display("FAIL %s/%s addr=%h sup=%0b map=%b actual=%h expected=%h",
                     tag, note, addr, supervisor, model_map, act, exp_v);
        end
        compared++;
        if ($countones(act) != 1) begin  // R11
            mismatched++;
            $display("FAIL R11 addr=%h actual=%h expected one-hot", addr, act);
        end
    endtask

    // compare what the previous inputs produced, then drive new ones
    task automatic step(input logic [31:0] a, input logic sup,
                        input logic we, input logic [4:0] wd, input string note);
        @(negedge clk);
        compare(note);
        addr = a; supervisor = sup; map_wr_en = we; map_wr_data = wd;
    endtask

    task automatic wr(input logic [4:0] wd);
        step(addr, supervisor, 1'b1, wd, "R2");
        step(addr, supervisor, 1'b0, wd, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        addr = 32'h0000_0100; supervisor = 1'b1;
        // R1: reset map -> address 0 reads ROM
        step(32'h0000_0000, 1'b0, 1'b0, 5'd0, "R1");
        step(32'h0000_0000, 1'b1, 1'b0, 5'd0, "R1");
        step(32'h0040_0000, 1'b1, 1'b0, 5'd0, "R7");
        // R3 supervisor, R6 tags in top byte, R10 windows
        step(32'hAB90_0000, 1'b1, 1'b0, 5'd0, "R6");
        step(32'h55F9_1234, 1'b1, 1'b0, 5'd0, "R6");
        step(32'h00FA_0000, 1'b1, 1'b0, 5'd0, "R10");
        step(32'h00FF_FFFF, 1'b1, 1'b0, 5'd0, "R10");
        step(32'h00C0_0000, 1'b1, 1'b0, 5'd0, "R9");
        step(32'h00A0_0000, 1'b1, 1'b0, 5'd0, "R9");
        // R2/R4: 32 MB user configuration, overlays both on
        wr(5'b01011);
        step(32'h0180_0000, 1'b0, 1'b0, 5'd0, "R9");
        step(32'h01F9_0000, 1'b0, 1'b0, 5'd0, "R4");
        step(32'h0100_0000, 1'b0, 1'b0, 5'd0, "R5");
        step(32'h0080_0000, 1'b0, 1'b0, 5'd0, "R7");
        step(32'h0040_0000, 1'b0, 1'b0, 5'd0, "R8");
        step(32'hFE40_0000, 1'b0, 1'b0, 5'd0, "R6");
        step(32'h0180_0000, 1'b1, 1'b0, 5'd0, "R3");
        // 512 MB and 4 GB
        wr(5'b10000);
        step(32'h11F0_0000, 1'b0, 1'b0, 5'd0, "R4");
        step(32'h0180_0000, 1'b0, 1'b0, 5'd0, "R5");
        step(32'h0000_0000, 1'b0, 1'b0, 5'd0, "R7");
        wr(5'b00000);
        step(32'h91FE_0000, 1'b0, 1'b0, 5'd0, "R4");
        step(32'h81FE_0000, 1'b0, 1'b0, 5'd0, "R5");
        step(32'h7FFF_FFFF, 1'b0, 1'b0, 5'd0, "R7");
        // mixed random traffic with occasional writes
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = $urandom;
            if (($urandom % 3) == 0) a = a | 32'h9180_0000;
            if (($urandom % 4) == 0) a[22:20] = 3'd7;
            step(a, 1'($urandom % 2), (($urandom % 16) == 0), 5'($urandom), "R4");
        end
        step(32'h0, 1'b1, 1'b0, 5'd0, "R11");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule